// File: doc/BRIEF.md
# Cursor Highlight and Light Pen Capture Unit

This block sits beside the refresh address generator of a character-based video timing controller. On every character clock it compares the running refresh address with a programmed 14-bit cursor location. It also checks that the current scanline within the character row lies inside a programmed band of lines. When both hold, the active display area is open and the blink phase allows it, the block raises an active-high cursor signal. The video logic downstream overlays that signal on the character cell.

The cursor is programmed through four plain configuration inputs:
- a start-line field that also carries a two-bit display mode,
- an end-line field,
- the high part of the cursor location,
- the low part of the cursor location.

The mode selects one of four behaviours: a steady cursor, a hidden cursor, or a cursor that blinks at one of two slow rates. The blink rates are derived from a field counter that advances on every rising edge of the vertical sync input.

The light pen strobe is asynchronous. It is passed through a synchronizer into the character clock domain. Its rising edge then freezes the refresh address of that clock into a capture register that the block only ever writes itself. The captured value is a held status word, not a stream: it has no valid/ready handshake and no back-pressure, and it stays put until the next rising edge of the strobe.

Top module: `cursor_pen_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cursor_out` is 0, `pen_addr` is 0 and the blink field count is 0.
- R2: With mode 00 the cursor is steady. `cursor_out` is 1 in the clock after an edge where all of the following held: `refresh_addr` equalled `{cur_addr_hi[5:0], cur_addr_lo[7:0]}`, `disp_en` was 1, and `raster_addr` was inside the line band.
- R3: The line band is start ≤ `raster_addr` ≤ end, inclusive, taking start from `cur_start_cfg[4:0]` and end from `cur_end_line`. When start > end the band is empty and the cursor never shows.
- R4: `cursor_out` is never 1 unless `disp_en` was 1 at the edge that produced it.
- R5: The mode is `cur_start_cfg[6:5]`. Mode 01 hides the cursor completely.
- R6: A field count advances by one on each clock edge that sees `vsync` high after it was low. Mode 10 shows the cursor only while (count mod 16) < 8, a blink at 1/16 of the field rate. The cursor evaluation at the edge that advances the count uses the count from before that advance.
- R7: Mode 11 shows the cursor only while (count mod 32) < 16, a blink at 1/32 of the field rate.
- R8: A rising edge of `pen_strobe` passes a two-stage synchronizer. With the strobe raised between clock edges, `pen_addr` takes the value `refresh_addr` had at the third following clock edge. It is unchanged after the second edge.
- R9: Holding `pen_strobe` high, or dropping it, does not change `pen_addr`, whatever `refresh_addr` does. Only a new low-to-high transition captures again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_addr | input | 14 | Current refresh address |
| raster_addr | input | 5 | Current scanline within the character row |
| disp_en | input | 1 | High inside the active display area |
| vsync | input | 1 | Vertical sync; rising edge advances the field count |
| cur_start_cfg | input | 7 | [4:0] first cursor line, [6:5] cursor mode |
| cur_end_line | input | 5 | Last cursor line |
| cur_addr_hi | input | 6 | Cursor location bits 13:8 |
| cur_addr_lo | input | 8 | Cursor location bits 7:0 |
| pen_strobe | input | 1 | Asynchronous light pen strobe |
| cursor_out | output | 1 | Active-high cursor signal, one clock after its inputs |
| pen_addr | output | 14 | Last captured refresh address |

## Verification
Two functions of the block can act in the same clock: a light pen capture, and a cursor hit on the same refresh address. The bench provokes this by parking the refresh address on the cursor location inside the line band while it raises the strobe. At the capture edge it requires both the cursor signal and the new captured value.

Two further events also share an edge: a vertical sync rising edge and a cursor evaluation. The randomized phase pulses vsync while blinking modes are active. A bench model of the field count then judges whether the cursor at that edge used the count from before the advance.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  typedef enum logic [1:0] {
    CUR_STEADY  = 2'b00,
    CUR_HIDDEN  = 2'b01,
    CUR_BLINK16 = 2'b10,
    CUR_BLINK32 = 2'b11
  } cur_mode_e;
endpackage

// File: rtl/cursor_blink.sv
module cursor_blink
  import cpl_pkg::*;
#(
  parameter int FIELD_W = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vsync,
  input  cur_mode_e mode,
  output logic      visible
);
  localparam int SLOW_BIT = FIELD_W - 1;
  localparam int FAST_BIT = FIELD_W - 2;

  logic               vs_q;
  logic [FIELD_W-1:0] field_cnt;
  logic               vs_rise;

  assign vs_rise = vsync & ~vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q      <= 1'b0;
      field_cnt <= '0;
    end else begin
      vs_q <= vsync;
      if (vs_rise) field_cnt <= field_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      CUR_STEADY:  visible = 1'b1;
      CUR_HIDDEN:  visible = 1'b0;
      CUR_BLINK16: visible = ~field_cnt[FAST_BIT];
      CUR_BLINK32: visible = ~field_cnt[SLOW_BIT];
      default:     visible = 1'b0;
    endcase
  end

  // R6: each vsync rising edge advances the field count by exactly one
  a_r6_field_step: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> field_cnt == $past(field_cnt) + 1'b1);
  // R6: without a rising edge the count holds
  a_r6_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(field_cnt));
endmodule

// File: rtl/cursor_match.sv
module cursor_match #(
  parameter int ADDR_W = 14,
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] refresh_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LINE_W-1:0] raster_addr,
  input  logic [LINE_W-1:0] first_line,
  input  logic [LINE_W-1:0] last_line,
  input  logic              disp_en,
  input  logic              visible,
  output logic              cursor_out
);
  logic addr_hit;
  logic in_band;

  assign addr_hit = (refresh_addr == cur_addr);
  assign in_band  = (raster_addr >= first_line) && (raster_addr <= last_line);

  always_ff @(posedge clk) begin
    if (!rst_n) cursor_out <= 1'b0;
    else        cursor_out <= addr_hit & in_band & disp_en & visible;
  end

  // R4: cursor only after an edge inside the active area
  a_r4_needs_disp: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_out |-> $past(disp_en));
  // R2: cursor only on the programmed location
  a_r2_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_out |-> $past(refresh_addr) == $past(cur_addr));
  // R3: cursor only inside the line band
  a_r3_line_band: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_out |-> ($past(raster_addr) >= $past(first_line)) &&
                   ($past(raster_addr) <= $past(last_line)));
endmodule

// File: rtl/pen_capture.sv
module pen_capture #(
  parameter int ADDR_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pen_strobe,
  input  logic [ADDR_W-1:0] refresh_addr,
  output logic [ADDR_W-1:0] pen_addr
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   edge_q;
  logic                   capture;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pen_strobe;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pen_strobe};
      end
    end
  endgenerate

  assign capture = sync_q[SYNC_STAGES-1] & ~edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q   <= 1'b0;
      pen_addr <= '0;
    end else begin
      edge_q <= sync_q[SYNC_STAGES-1];
      if (capture) pen_addr <= refresh_addr;
    end
  end

  // R8: a capture loads the refresh address of that edge
  a_r8_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> pen_addr == $past(refresh_addr));
  // R9: no capture, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(pen_addr));
endmodule

// File: rtl/cursor_pen_unit.sv
module cursor_pen_unit
  import cpl_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int LINE_W      = 5,
  parameter int FIELD_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] refresh_addr,
  input  logic [LINE_W-1:0] raster_addr,
  input  logic              disp_en,
  input  logic              vsync,
  input  logic [LINE_W+1:0] cur_start_cfg,
  input  logic [LINE_W-1:0] cur_end_line,
  input  logic [ADDR_W-9:0] cur_addr_hi,
  input  logic [7:0]        cur_addr_lo,
  input  logic              pen_strobe,
  output logic              cursor_out,
  output logic [ADDR_W-1:0] pen_addr
);
  cur_mode_e         mode;
  logic              visible;
  logic [ADDR_W-1:0] cur_addr;

  assign mode     = cur_mode_e'(cur_start_cfg[LINE_W+1:LINE_W]);
  assign cur_addr = {cur_addr_hi, cur_addr_lo};

  cursor_blink #(.FIELD_W(FIELD_W)) u_blink (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .mode(mode), .visible(visible)
  );

  cursor_match #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_match (
    .clk(clk), .rst_n(rst_n), .refresh_addr(refresh_addr), .cur_addr(cur_addr),
    .raster_addr(raster_addr), .first_line(cur_start_cfg[LINE_W-1:0]),
    .last_line(cur_end_line), .disp_en(disp_en), .visible(visible),
    .cursor_out(cursor_out)
  );

  pen_capture #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_pen (
    .clk(clk), .rst_n(rst_n), .pen_strobe(pen_strobe),
    .refresh_addr(refresh_addr), .pen_addr(pen_addr)
  );

  // R5: hidden mode never shows the cursor
  a_r5_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_out |-> $past(cur_start_cfg[LINE_W+1:LINE_W]) != 2'b01);
endmodule

// File: tb/cursor_pen_unit_bench.sv
module cursor_pen_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] refresh_addr = '0;
  logic [4:0]  raster_addr = '0;
  logic        disp_en = 1'b0;
  logic        vsync = 1'b0;
  logic [6:0]  cur_start_cfg = '0;
  logic [4:0]  cur_end_line = '0;
  logic [5:0]  cur_addr_hi = '0;
  logic [7:0]  cur_addr_lo = '0;
  logic        pen_strobe = 1'b0;
  logic        cursor_out;
  logic [13:0] pen_addr;

  int checks = 0;
  int fails = 0;
  int fcount = 0;
  bit prev_vs = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_pen_unit u_cursor_pen_unit (
    .clk(clk), .rst_n(rst_n), .refresh_addr(refresh_addr), .raster_addr(raster_addr),
    .disp_en(disp_en), .vsync(vsync), .cur_start_cfg(cur_start_cfg),
    .cur_end_line(cur_end_line), .cur_addr_hi(cur_addr_hi), .cur_addr_lo(cur_addr_lo),
    .pen_strobe(pen_strobe), .cursor_out(cursor_out), .pen_addr(pen_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_cursor(input int fc);
    bit vis;
    case (cur_start_cfg[6:5])
      2'b00: vis = 1'b1;
      2'b01: vis = 1'b0;
      2'b10: vis = (fc % 16) < 8;
      default: vis = (fc % 32) < 16;
    endcase
    return vis && disp_en && (refresh_addr == {cur_addr_hi, cur_addr_lo}) &&
           (raster_addr >= cur_start_cfg[4:0]) && (raster_addr <= cur_end_line);
  endfunction

  // drive at negedge, predict, advance one clock, compare
  task automatic step_cursor(input string req);
    bit e;
    e = exp_cursor(fcount);
    if (vsync && !prev_vs) fcount++;
    prev_vs = vsync;
    @(negedge clk);
    check(req, cursor_out, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cursor", cursor_out, 0);
    check("R1 pen", pen_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cursor after release", cursor_out, 0);

    // R2 / R10-style directed steady hit
    cur_addr_hi = 6'h2A; cur_addr_lo = 8'h5C;
    cur_start_cfg = {2'b00, 5'd3}; cur_end_line = 5'd6;
    refresh_addr = 14'h2A5C; raster_addr = 5'd3; disp_en = 1'b1;
    step_cursor("R2 steady hit at first line");
    raster_addr = 5'd6; step_cursor("R3 last line inclusive");
    raster_addr = 5'd7; step_cursor("R3 past last line");
    raster_addr = 5'd2; step_cursor("R3 before first line");
    raster_addr = 5'd4; refresh_addr = 14'h2A5D; step_cursor("R2 address miss");
    refresh_addr = 14'h2A5C; disp_en = 1'b0; step_cursor("R4 display off");
    disp_en = 1'b1; cur_start_cfg = {2'b01, 5'd3}; step_cursor("R5 hidden mode");
    cur_start_cfg = {2'b00, 5'd9}; cur_end_line = 5'd4; raster_addr = 5'd5;
    step_cursor("R3 empty band");
    check("R3 empty band output", cursor_out, 0);

    // random phase: R2..R7 with vsync pulses
    for (int i = 0; i < 3000; i++) begin
      cur_start_cfg[6:5] = 2'($urandom_range(0, 3));
      cur_start_cfg[4:0] = 5'($urandom_range(0, 8));
      cur_end_line = 5'($urandom_range(2, 12));
      raster_addr = 5'($urandom_range(0, 14));
      disp_en = ($urandom_range(0, 9) != 0);
      refresh_addr = ($urandom_range(0, 2) != 0) ? {cur_addr_hi, cur_addr_lo}
                                                 : 14'($urandom);
      vsync = ($urandom_range(0, 3) == 0);
      case (cur_start_cfg[6:5])
        2'b10: step_cursor("R6 blink16 random");
        2'b11: step_cursor("R7 blink32 random");
        2'b01: step_cursor("R5 hidden random");
        default: step_cursor("R2 steady random");
      endcase
    end
    vsync = 1'b0;
    @(negedge clk);
    prev_vs = 1'b0;

    // R8 capture latency, concurrent with cursor hit
    cur_start_cfg = {2'b00, 5'd1}; cur_end_line = 5'd5; raster_addr = 5'd2;
    disp_en = 1'b1; refresh_addr = 14'h1111;
    pen_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 no capture after second edge", pen_addr, 0);
    refresh_addr = {cur_addr_hi, cur_addr_lo};
    @(negedge clk);
    check("R8 captured at third edge", pen_addr, {cur_addr_hi, cur_addr_lo});
    check("R2 cursor in capture cycle", cursor_out, 1);
    // R9 held high, then dropped
    for (int k = 0; k < 6; k++) begin
      refresh_addr = 14'($urandom);
      @(negedge clk);
    end
    check("R9 held strobe", pen_addr, {cur_addr_hi, cur_addr_lo});
    pen_strobe = 1'b0;
    for (int k = 0; k < 6; k++) begin
      refresh_addr = 14'($urandom);
      @(negedge clk);
    end
    check("R9 dropped strobe", pen_addr, {cur_addr_hi, cur_addr_lo});
    // R8 second capture
    refresh_addr = 14'h3FFF;
    pen_strobe = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 second capture", pen_addr, 14'h3FFF);
    pen_strobe = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule